// File: doc/BRIEF.md
# Power-Function Special-Case Unit

This block is the exception and sign stage of a floating-point x^y operator. Each operand is carried as a 2-bit class code, a sign, an EXP_W-bit biased exponent and a FRAC_W-bit fraction. The exponent bias is 2^(EXP_W-1)-1, and subnormals do not exist. The block takes the two operands, a rule-set select, and the result and range flags that the log/multiply/exp datapath produces for the same pair. It returns the final result.

For each operand pair the unit first checks whether the pair falls into a forced outcome. A forced outcome is 1, zero, infinity or NaN, each with its sign. The unit also works out whether y is an integer and whether it is odd, and uses that for the sign of a negative base. It then merges any forced outcome with the computed value. Two rule sets are available: the traditional one, which allows negative bases with integer exponents, and the restricted one, which is defined only through exp(y·ln x). A rule-set input selects between them.

Top module: `pwr_special_unit`

## Requirements
- R1: Class codes are 00 zero, 01 normal, 10 infinity, 11 NaN. Every output is registered, so the result for an input accepted with `in_valid` appears one clock later with `out_valid` high. During reset, `out_valid` is 0 and `out_exc` is 00.
- R2: The integer flag for y is set when y is zero, or when y is normal and Ey - bias - FRAC_W + (trailing zeros of the fraction, FRAC_W if the fraction is zero) is at least 0. The odd flag is set only for a normal y where that sum is exactly 0. Infinite and NaN y give 0 for both flags. Both flags appear on `out_y_int` and `out_y_odd`.
- R3: With `mode`=0, y = ±0 gives exactly 1.0 (class 01, sign 0, exponent = bias, fraction 0) for every x, including NaN. x = +1 gives 1.0 for every y, including NaN.
- R4: With `mode`=0, any other NaN operand gives NaN. A finite negative nonzero x with a finite non-integer y gives NaN.
- R5: With `mode`=0, a finite negative x with an integer y gives the computed value. Its sign is 1 exactly when y is odd.
- R6: With `mode`=0 and x = ±0, the results are as follows. A negative y gives infinity; a positive y gives zero. The result is negative only when x is -0 and y is an odd integer. y = -inf gives +inf and y = +inf gives +0.
- R7: With an infinite y, a base of magnitude below 1 gives +0 for +inf and +inf for -inf, and a base of magnitude above 1 (including infinity) gives the reverse. With `mode`=0, x = -1 and y = ±inf gives 1.0.
- R8: x = +inf gives +inf for positive y and +0 for negative y. With `mode`=0, x = -inf and a positive y give -inf for an odd integer y and +inf otherwise. A negative y gives zero, negative only for an odd integer y.
- R9: With `mode`=1, NaN is the result for all of the following: any NaN operand, any negative nonzero x including -inf, ±0^±0, +inf^±0, ±1^±inf, and -0^+inf.
- R10: With `mode`=1, x = ±0 with a nonzero finite y gives +inf for negative y and +0 for positive y. A finite positive x with y = ±0 gives 1.0, and x = 1 with a finite y gives 1.0.
- R11: When no forced outcome applies, `core_unf` gives +0, otherwise `core_ovf` gives +inf, and otherwise the output is class 01 with `core_exp` and `core_frac`. A forced outcome always overrides the core flags and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair and core result present |
| mode | input | 1 | 0 traditional rules, 1 restricted rules |
| x_exc | input | 2 | Class code of x |
| x_sign | input | 1 | Sign of x |
| x_exp | input | EXP_W | Biased exponent of x |
| x_frac | input | FRAC_W | Fraction of x |
| y_exc | input | 2 | Class code of y |
| y_sign | input | 1 | Sign of y |
| y_exp | input | EXP_W | Biased exponent of y |
| y_frac | input | FRAC_W | Fraction of y |
| core_exp | input | EXP_W | Exponent of the datapath result |
| core_frac | input | FRAC_W | Fraction of the datapath result |
| core_unf | input | 1 | Datapath result below smallest normal |
| core_ovf | input | 1 | Datapath result above largest finite |
| out_valid | output | 1 | Result valid |
| out_exc | output | 2 | Result class code |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent (0 unless normal) |
| out_frac | output | FRAC_W | Result fraction (0 unless normal) |
| out_y_int | output | 1 | y is an integer |
| out_y_odd | output | 1 | y is an odd integer |

## Verification
Every result, flag and sign is due exactly one rising edge after the pair is presented. The driver applies a pair at a falling edge and queues its expected result. The monitor pops and compares at the next falling edge on which `out_valid` is high, so each comparison sees the value registered half a period earlier and never one in transition. The driver presents pairs back to back, so a result that slips by a cycle is compared against the wrong queued entry.

// File: rtl/pwr_special_unit.sv
module pwr_special_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              mode,
  input  logic [1:0]        x_exc,
  input  logic              x_sign,
  input  logic [EXP_W-1:0]  x_exp,
  input  logic [FRAC_W-1:0] x_frac,
  input  logic [1:0]        y_exc,
  input  logic              y_sign,
  input  logic [EXP_W-1:0]  y_exp,
  input  logic [FRAC_W-1:0] y_frac,
  input  logic [EXP_W-1:0]  core_exp,
  input  logic [FRAC_W-1:0] core_frac,
  input  logic              core_unf,
  input  logic              core_ovf,
  output logic              out_valid,
  output logic [1:0]        out_exc,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac,
  output logic              out_y_int,
  output logic              out_y_odd
);

  localparam int BIAS = 2**(EXP_W-1) - 1;
  localparam int CW   = $clog2(FRAC_W + 1);
  localparam int SW   = EXP_W + CW + 2;
  localparam logic [1:0] C_ZERO = 2'b00, C_NORM = 2'b01, C_INF = 2'b10, C_NAN = 2'b11;

  typedef enum logic [2:0] {K_CALC, K_ZERO, K_ONE, K_INF, K_NAN} kind_t;

  logic x_zero, x_norm, x_inf, x_nan, y_zero, y_norm, y_inf, y_nan;
  assign x_zero = x_exc == C_ZERO;
  assign x_norm = x_exc == C_NORM;
  assign x_inf  = x_exc == C_INF;
  assign x_nan  = x_exc == C_NAN;
  assign y_zero = y_exc == C_ZERO;
  assign y_norm = y_exc == C_NORM;
  assign y_inf  = y_exc == C_INF;
  assign y_nan  = y_exc == C_NAN;

  logic x_unit, x_small;
  assign x_unit  = x_norm && (x_exp == EXP_W'(BIAS)) && (x_frac == '0);
  assign x_small = x_norm && (x_exp < EXP_W'(BIAS));

  logic [CW-1:0] tz;
  always_comb begin
    tz = CW'(FRAC_W);
    for (int i = FRAC_W - 1; i >= 0; i--)
      if (y_frac[i]) tz = CW'(i);
  end

  logic signed [SW-1:0] lsb_w;
  assign lsb_w = $signed({2'b00, y_exp}) + $signed({{(SW-CW){1'b0}}, tz})
               - SW'(BIAS) - SW'(FRAC_W);

  logic y_int, y_odd;
  assign y_int = y_zero || (y_norm && lsb_w >= 0);
  assign y_odd = y_norm && lsb_w == 0;

  kind_t kind;
  logic  fsign;
  always_comb begin
    kind  = K_CALC;
    fsign = 1'b0;
    if (!mode) begin
      if (y_zero || (x_unit && !x_sign))      kind = K_ONE;
      else if (x_nan || y_nan)                kind = K_NAN;
      else if (x_unit && y_inf)               kind = K_ONE;
      else if (x_zero) begin
        kind  = y_sign ? K_INF : K_ZERO;
        fsign = x_sign && y_odd;
      end
      else if (y_inf)                         kind = (x_small ^ y_sign) ? K_ZERO : K_INF;
      else if (x_inf) begin
        kind  = y_sign ? K_ZERO : K_INF;
        fsign = x_sign && y_odd;
      end
      else if (x_sign && !y_int)              kind = K_NAN;
    end else begin
      if (x_nan || y_nan)                     kind = K_NAN;
      else if (x_sign && !x_zero)             kind = K_NAN;
      else if (x_zero) begin
        if (y_zero || (y_inf && !y_sign && x_sign)) kind = K_NAN;
        else                                  kind = y_sign ? K_INF : K_ZERO;
      end
      else if (x_inf)                         kind = y_zero ? K_NAN : (y_sign ? K_ZERO : K_INF);
      else if (x_unit)                        kind = y_inf ? K_NAN : K_ONE;
      else if (y_zero)                        kind = K_ONE;
      else if (y_inf)                         kind = (x_small ^ y_sign) ? K_ZERO : K_INF;
    end
  end

  logic [1:0]        n_exc;
  logic              n_sign;
  logic [EXP_W-1:0]  n_exp;
  logic [FRAC_W-1:0] n_frac;
  always_comb begin
    n_exc  = C_NAN;
    n_sign = 1'b0;
    n_exp  = '0;
    n_frac = '0;
    case (kind)
      K_ZERO: begin n_exc = C_ZERO; n_sign = fsign; end
      K_INF:  begin n_exc = C_INF;  n_sign = fsign; end
      K_ONE:  begin n_exc = C_NORM; n_exp = EXP_W'(BIAS); end
      K_NAN:  n_exc = C_NAN;
      default: begin
        if (core_unf)      n_exc = C_ZERO;
        else if (core_ovf) n_exc = C_INF;
        else begin
          n_exc  = C_NORM;
          n_sign = !mode && x_sign && y_odd;
          n_exp  = core_exp;
          n_frac = core_frac;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_exc   <= C_ZERO;
      out_sign  <= 1'b0;
      out_exp   <= '0;
      out_frac  <= '0;
      out_y_int <= 1'b0;
      out_y_odd <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_exc   <= n_exc;
        out_sign  <= n_sign;
        out_exp   <= n_exp;
        out_frac  <= n_frac;
        out_y_int <= y_int;
        out_y_odd <= y_odd;
      end
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R2
  odd_is_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_y_odd |-> out_y_int);

  // R4
  nan_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode && x_exc == C_NAN && y_exc != C_ZERO) |=> out_exc == C_NAN);

  // R6
  zero_base_neg_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode && x_exc == C_ZERO && y_exc == C_NORM && y_sign) |=> out_exc == C_INF);

  // R9
  powr_neg_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode && x_sign && x_exc != C_ZERO) |=> out_exc == C_NAN);

  // R11
  core_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode && x_exc == C_NORM && !x_sign && x_exp != EXP_W'(BIAS)
     && y_exc == C_NORM && core_ovf && !core_unf) |=> (out_exc == C_INF && !out_sign));

endmodule

// File: tb/pwr_special_unit_bench.sv
module pwr_special_unit_bench;
  localparam int EW = 8, FW = 23, B = 127;
  localparam logic [7:0]  CE = 8'h55;
  localparam logic [22:0] CF = 23'h01234;

  logic clk = 0, rst_n = 0, in_valid = 0, mode = 0;
  logic [1:0] x_exc = 0, y_exc = 0;
  logic x_sign = 0, y_sign = 0;
  logic [EW-1:0] x_exp = 0, y_exp = 0;
  logic [FW-1:0] x_frac = 0, y_frac = 0;
  logic core_unf = 0, core_ovf = 0;
  logic out_valid, out_sign, out_y_int, out_y_odd;
  logic [1:0] out_exc;
  logic [EW-1:0] out_exp;
  logic [FW-1:0] out_frac;

  always #2.5 clk = ~clk;

  pwr_special_unit #(.EXP_W(EW), .FRAC_W(FW)) u_pwr_special_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .x_exc(x_exc), .x_sign(x_sign), .x_exp(x_exp), .x_frac(x_frac),
    .y_exc(y_exc), .y_sign(y_sign), .y_exp(y_exp), .y_frac(y_frac),
    .core_exp(CE), .core_frac(CF), .core_unf(core_unf), .core_ovf(core_ovf),
    .out_valid(out_valid), .out_exc(out_exc), .out_sign(out_sign),
    .out_exp(out_exp), .out_frac(out_frac), .out_y_int(out_y_int), .out_y_odd(out_y_odd));

  int checks = 0, errors = 0;
  logic [37:0] exp_q[$];
  string       req_q[$];

  function automatic logic [33:0] fp(logic [1:0] c, logic s, logic [7:0] e, logic [22:0] f);
    return {c, s, e, f};
  endfunction

  localparam logic [1:0] Z = 2'b00, N = 2'b01, I = 2'b10, Q = 2'b11;
  logic [33:0] P0, M0, PI, MI, QN, ONE, MONE, TWO, MTWO, HALF, THREE, MTHREE, M2H, MM2, MM3, P2H, ONEH, BIGE;
  initial begin
    P0 = fp(Z,0,0,0); M0 = fp(Z,1,0,0); PI = fp(I,0,0,0); MI = fp(I,1,0,0); QN = fp(Q,0,0,0);
    ONE = fp(N,0,B,0); MONE = fp(N,1,B,0); TWO = fp(N,0,B+1,0); MTWO = fp(N,1,B+1,0);
    HALF = fp(N,0,B-1,0); THREE = fp(N,0,B+1,23'h400000); MTHREE = fp(N,1,B+1,23'h400000);
    P2H = fp(N,0,B+1,23'h200000); M2H = fp(N,1,B+1,23'h200000);
    MM2 = fp(N,1,B+1,0); MM3 = MTHREE; ONEH = fp(N,0,B,23'h400000); BIGE = fp(N,0,B+24,0);
  end

  // item: exc, sign, exp, frac, chk_fr, chk_y, yi, yo
  task automatic send(string req, logic md, logic [33:0] x, logic [33:0] y, logic unf, logic ovf,
                      logic [1:0] ec, logic es, int kind, logic cy, logic yi, logic yo);
    logic [7:0] ee; logic [22:0] ef; logic cf;
    ee = 0; ef = 0; cf = (ec == N);
    if (kind == 1) ee = B[7:0];
    if (kind == 2) begin ee = CE; ef = CF; end
    @(negedge clk);
    in_valid = 1; mode = md;
    {x_exc, x_sign, x_exp, x_frac} = x;
    {y_exc, y_sign, y_exp, y_frac} = y;
    core_unf = unf; core_ovf = ovf;
    exp_q.push_back({ec, es, ee, ef, cf, cy, yi, yo});
    req_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [37:0] e; string r;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected result exc=%b expected none", out_exc);
      end else begin
        e = exp_q.pop_front(); r = req_q.pop_front();
        if (out_exc != e[37:36] || out_sign != e[35] ||
            (e[3] && (out_exp != e[34:27] || out_frac != e[26:4])) ||
            (e[2] && (out_y_int != e[1] || out_y_odd != e[0]))) begin
          errors++;
          $display("FAIL %s actual exc=%b s=%b e=%h f=%h int=%b odd=%b expected exc=%b s=%b e=%h f=%h int=%b odd=%b",
                   r, out_exc, out_sign, out_exp, out_frac, out_y_int, out_y_odd,
                   e[37:36], e[35], e[34:27], e[26:4], e[1], e[0]);
        end
      end
    end
  end

  initial begin : wd
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_exc !== 2'b00) begin
      errors++;
      $display("FAIL R1 reset actual valid=%b exc=%b expected 0 00", out_valid, out_exc);
    end
    rst_n = 1;
    // R3
    send("R3", 0, QN, P0, 0,0, N,0,1, 0,0,0);
    send("R3", 0, ONE, QN, 0,0, N,0,1, 0,0,0);
    // R4
    send("R4", 0, TWO, QN, 0,0, Q,0,0, 0,0,0);
    send("R4", 0, MTWO, P2H, 0,0, Q,0,0, 1,0,0);
    // R5
    send("R5", 0, MTWO, THREE, 0,0, N,1,2, 1,1,1);
    send("R5", 0, MTWO, TWO, 0,0, N,0,2, 1,1,0);
    // R2
    send("R2", 0, TWO, HALF, 0,0, N,0,2, 1,0,0);
    send("R2", 0, THREE, ONE, 0,0, N,0,2, 1,1,1);
    send("R2", 0, TWO, BIGE, 0,0, N,0,2, 1,1,0);
    send("R2", 0, TWO, ONEH, 0,0, N,0,2, 1,0,0);
    send("R2", 0, TWO, PI, 0,0, I,0,0, 1,0,0);
    // R6
    send("R6", 0, M0, MTHREE, 0,0, I,1,0, 0,0,0);
    send("R6", 0, M0, MM2, 0,0, I,0,0, 0,0,0);
    send("R6", 0, M0, THREE, 0,0, Z,1,0, 0,0,0);
    send("R6", 0, M0, P2H, 0,0, Z,0,0, 0,0,0);
    send("R6", 0, P0, MI, 0,0, I,0,0, 0,0,0);
    send("R6", 0, M0, PI, 0,0, Z,0,0, 0,0,0);
    // R7
    send("R7", 0, HALF, PI, 0,0, Z,0,0, 0,0,0);
    send("R7", 0, HALF, MI, 0,0, I,0,0, 0,0,0);
    send("R7", 0, MTWO, PI, 0,0, I,0,0, 0,0,0);
    send("R7", 0, TWO, MI, 0,0, Z,0,0, 0,0,0);
    send("R7", 0, MONE, PI, 0,0, N,0,1, 0,0,0);
    send("R7", 1, HALF, PI, 0,0, Z,0,0, 0,0,0);
    send("R7", 1, PI, MI, 0,0, Z,0,0, 0,0,0);
    // R8
    send("R8", 0, PI, TWO, 0,0, I,0,0, 0,0,0);
    send("R8", 0, PI, MM2, 0,0, Z,0,0, 0,0,0);
    send("R8", 0, MI, THREE, 0,0, I,1,0, 0,0,0);
    send("R8", 0, MI, TWO, 0,0, I,0,0, 0,0,0);
    send("R8", 0, MI, MM3, 0,0, Z,1,0, 0,0,0);
    send("R8", 1, PI, TWO, 0,0, I,0,0, 0,0,0);
    // R9
    send("R9", 1, MTWO, TWO, 0,0, Q,0,0, 0,0,0);
    send("R9", 1, MI, TWO, 0,0, Q,0,0, 0,0,0);
    send("R9", 1, P0, M0, 0,0, Q,0,0, 0,0,0);
    send("R9", 1, PI, P0, 0,0, Q,0,0, 0,0,0);
    send("R9", 1, MONE, PI, 0,0, Q,0,0, 0,0,0);
    send("R9", 1, ONE, MI, 0,0, Q,0,0, 0,0,0);
    send("R9", 1, M0, PI, 0,0, Q,0,0, 0,0,0);
    send("R9", 1, QN, P0, 0,0, Q,0,0, 0,0,0);
    send("R9", 1, ONE, QN, 0,0, Q,0,0, 0,0,0);
    // R10
    send("R10", 1, P0, MM2, 0,0, I,0,0, 0,0,0);
    send("R10", 1, M0, THREE, 0,0, Z,0,0, 0,0,0);
    send("R10", 1, THREE, M0, 0,0, N,0,1, 0,0,0);
    send("R10", 1, ONE, P2H, 0,0, N,0,1, 0,0,0);
    send("R10", 1, TWO, M2H, 0,0, N,0,2, 0,0,0);
    // R11
    send("R11", 0, TWO, THREE, 1,0, Z,0,0, 0,0,0);
    send("R11", 0, TWO, THREE, 0,1, I,0,0, 0,0,0);
    send("R11", 0, MTWO, THREE, 0,1, I,0,0, 0,0,0);
    send("R11", 0, QN, TWO, 0,1, Q,0,0, 0,0,0);
    send("R11", 1, TWO, THREE, 0,1, I,0,0, 0,0,0);
    send("R11", 1, PI, TWO, 1,0, I,0,0, 0,0,0);
    @(negedge clk);
    in_valid = 0;
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 pending actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule